// File: doc/BRIEF.md
# Paged Register SPI Bridge Master

This block lets on-chip logic read and write the configuration registers of an external Ethernet switch over a four-wire serial link: an active-low select, a clock, a data line out and a data line in. The switch's register space is addressed as a page number and an offset within that page, both eight bits wide. A host raises `start` for one cycle with a page, an offset, a direction, a byte count of 1, 2 or 4 and, for writes, the data. The block answers with a one-cycle `done` pulse, together with read data or an error flag.

The block keeps a copy of the page the switch currently has selected. If a request names a different page, the block first sends a separate page-select frame. If the page matches, that frame is left out. Writes go out in one frame. Reads use a fast-read command, then keep clocking status bytes until the switch raises its acknowledge bit, and only then collect the data. If the acknowledge never comes after a fixed number of status bytes, the read is abandoned and flagged. Every clock phase and select set-up interval is counted in system clocks derived from the `CLK_HZ` parameter, so the microsecond minimums of the link hold at any system frequency.

Top module: `paged_spi_reg_master`

## Requirements
- R1: Whenever `spi_ss_n` is high (including from reset), `spi_sclk` and `spi_mosi` are low. After reset, `done`, `timeout` and `bad_len` are low.
- R2: Every frame is a whole number of bytes. Each byte is shifted most-significant bit first. `spi_mosi` changes only while `spi_sclk` is low and is held for the whole high phase, so it is valid at the rising edge.
- R3: Every low and high phase of `spi_sclk` inside a frame lasts at least 2 µs. At least 1 µs passes between the fall of `spi_ss_n` and the first rising clock edge. At least 1 µs also passes between the last falling clock edge and the rise of `spi_ss_n`.
- R4: When the requested page differs from the cached page, the block first sends a three-byte frame: 0x61, 0xFF, then the new page. The cache holds no valid page after reset, so the first access always sends this frame.
- R5: When the requested page equals the cached page, no page frame is sent. The cache survives write, read and timed-out accesses.
- R6: A write is one frame: 0x61, the offset, then `len` data bytes taken from `wdata`, least-significant byte first.
- R7: A read is one frame: 0x10, the offset, then status bytes until one arrives with bit 0 set, then `len` data bytes. MISO is sampled at the end of each low phase. Data byte k lands in `rdata[8k+7:8k]`, and unused upper bytes read as zero.
- R8: If `ACK_TRIES` status bytes (100 by default) all arrive with bit 0 clear, the frame is closed, and `done` is given with `timeout` high.
- R9: A `len` other than 1, 2 or 4 gives `done` with `bad_len` high in the cycle after `start`, with no select activity and no change to the cached page.
- R10: `done` is a one-cycle pulse, given once per accepted request. A `start` while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| wr | input | 1 | 1 = register write, 0 = register read |
| page | input | 8 | Register page |
| ofs | input | 8 | Register offset within the page |
| len | input | 3 | Byte count (1, 2 or 4) |
| wdata | input | 32 | Write data, byte 0 sent first |
| rdata | output | 32 | Read data, valid with `done` |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Read acknowledge never arrived (with `done`) |
| bad_len | output | 1 | Request rejected for its length (with `done`) |
| spi_ss_n | output | 1 | Active-low select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the switch |
| spi_miso | input | 1 | Serial data from the switch |

## Verification
A behavioural switch model in the bench captures every frame and answers reads with a chosen number of non-acknowledge status bytes (0xFE, whose other bits are set, so only bit 0 can be what counts), then an acknowledge, then data. Writes of 4 and 2 bytes, and later a 1-byte write, tell byte order apart and show whether the page frame is present. Reads with 0, 3 and 5 non-acknowledge bytes and lengths of 1, 2 and 4 separate the polling count from the data capture. A read that never gets an acknowledge, lengths 0 and 3, a restart attempt during a busy frame, and page changes after a timeout cover the cache and rejection paths. Clock phase and select set-up lengths are measured on every clock.

// File: rtl/regspi_pkg.sv
package regspi_pkg;
  localparam logic [7:0] CMD_NORMAL_WR = 8'h61;
  localparam logic [7:0] CMD_FAST_RD   = 8'h10;
  localparam logic [7:0] PAGE_SEL_OFS  = 8'hFF;
  localparam logic [7:0] FILL_BYTE     = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_SHIFT, ST_WAIT, ST_HOLD, ST_GAP
  } seq_state_t;

  typedef enum logic [1:0] {FR_PAGE, FR_WRITE, FR_READ} frame_t;

  typedef enum logic [1:0] {RS_HEAD, RS_POLL, RS_DATA} stage_t;
endpackage

// File: rtl/regspi_byte_phy.sv
module regspi_byte_phy #(
  parameter int PHASE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  output logic       fin,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int TW = $clog2(PHASE_CYC + 1);

  logic          active;
  logic [2:0]    bitn;
  logic [TW-1:0] tmr;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      bitn   <= '0;
      tmr    <= '0;
      sh     <= '0;
      rx     <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          sclk   <= 1'b0;
          mosi   <= tx[7];
          sh     <= {tx[6:0], 1'b0};
          bitn   <= '0;
          tmr    <= TW'(PHASE_CYC - 1);
        end
      end else if (tmr != '0) begin
        tmr <= tmr - TW'(1);
      end else if (!sclk) begin
        // end of low phase: sample input, raise clock
        rx   <= {rx[6:0], miso};
        sclk <= 1'b1;
        tmr  <= TW'(PHASE_CYC - 1);
      end else if (bitn == 3'd7) begin
        active <= 1'b0;
        sclk   <= 1'b0;
        mosi   <= 1'b0;
        fin    <= 1'b1;
      end else begin
        sclk <= 1'b0;
        mosi <= sh[7];
        sh   <= {sh[6:0], 1'b0};
        bitn <= bitn + 3'd1;
        tmr  <= TW'(PHASE_CYC - 1);
      end
    end
  end
endmodule

// File: rtl/regspi_seq.sv
module regspi_seq
  import regspi_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int ACK_TRIES = 100,
  parameter int MAX_BYTES = 4,
  localparam int LW  = $clog2(MAX_BYTES + 1),
  localparam int DW  = 8 * MAX_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [7:0]    page,
  input  logic [7:0]    ofs,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] wdata,
  output logic          phy_go,
  output logic [7:0]    phy_tx,
  input  logic          phy_fin,
  input  logic [7:0]    phy_rx,
  output logic          ss_n,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          timeout,
  output logic          bad_len
);
  localparam int DIW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int SW  = $clog2(SETUP_CYC + 1);
  localparam int RW  = $clog2(ACK_TRIES + 1);

  seq_state_t     st;
  frame_t         fr;
  stage_t         rs;
  logic [1:0]     hc;
  logic [DIW-1:0] didx;
  logic [RW-1:0]  tries;
  logic [SW-1:0]  tmr;
  logic           r_wr, timed_out;
  logic [7:0]     r_page, r_ofs, cur_page;
  logic           page_ok;
  logic [LW-1:0]  r_len;
  logic [DW-1:0]  r_wdata, acc;
  logic           len_ok, need_page, last_data;

  always_comb begin
    len_ok    = (len != '0) && ((len & (len - LW'(1))) == '0) && (len <= LW'(MAX_BYTES));
    need_page = !page_ok || (page != cur_page);
    last_data = (LW'(didx) == (r_len - LW'(1)));
    phy_go    = (st == ST_SHIFT);
    phy_tx    = FILL_BYTE;
    unique case (rs)
      RS_HEAD: begin
        if (hc == 2'd0)      phy_tx = (fr == FR_READ) ? CMD_FAST_RD : CMD_NORMAL_WR;
        else if (hc == 2'd1) phy_tx = (fr == FR_PAGE) ? PAGE_SEL_OFS : r_ofs;
        else                 phy_tx = r_page;
      end
      RS_DATA: if (fr == FR_WRITE) phy_tx = r_wdata[{didx, 3'b000} +: 8];
      default: phy_tx = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; fr <= FR_PAGE; rs <= RS_HEAD;
      hc <= '0; didx <= '0; tries <= '0; tmr <= '0;
      r_wr <= 1'b0; timed_out <= 1'b0;
      r_page <= '0; r_ofs <= '0; cur_page <= '0; page_ok <= 1'b0;
      r_len <= '0; r_wdata <= '0; acc <= '0;
      ss_n <= 1'b1; rdata <= '0;
      done <= 1'b0; timeout <= 1'b0; bad_len <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      bad_len <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          r_wr <= wr; r_page <= page; r_ofs <= ofs;
          r_len <= len; r_wdata <= wdata;
          acc <= '0; timed_out <= 1'b0;
          if (!len_ok) begin
            done    <= 1'b1;
            bad_len <= 1'b1;
          end else begin
            fr   <= need_page ? FR_PAGE : (wr ? FR_WRITE : FR_READ);
            rs   <= RS_HEAD;
            hc   <= '0;
            ss_n <= 1'b0;
            tmr  <= SW'(SETUP_CYC - 1);
            st   <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (tmr == '0) st <= ST_SHIFT;
          else tmr <= tmr - SW'(1);
        end
        ST_SHIFT: st <= ST_WAIT;
        ST_WAIT: if (phy_fin) begin
          st <= ST_SHIFT;
          unique case (rs)
            RS_HEAD: begin
              if (fr == FR_PAGE && hc == 2'd2) begin
                st  <= ST_HOLD;
                tmr <= SW'(SETUP_CYC - 1);
              end else if (fr != FR_PAGE && hc == 2'd1) begin
                rs    <= (fr == FR_READ) ? RS_POLL : RS_DATA;
                didx  <= '0;
                tries <= '0;
              end else begin
                hc <= hc + 2'd1;
              end
            end
            RS_POLL: begin
              if (phy_rx[0]) begin
                rs <= RS_DATA;
              end else if (tries == RW'(ACK_TRIES - 1)) begin
                timed_out <= 1'b1;
                st        <= ST_HOLD;
                tmr       <= SW'(SETUP_CYC - 1);
              end else begin
                tries <= tries + RW'(1);
              end
            end
            default: begin
              if (fr == FR_READ) acc[{didx, 3'b000} +: 8] <= phy_rx;
              if (last_data) begin
                st  <= ST_HOLD;
                tmr <= SW'(SETUP_CYC - 1);
              end else begin
                didx <= didx + DIW'(1);
              end
            end
          endcase
        end
        ST_HOLD: begin
          if (tmr == '0) begin
            ss_n <= 1'b1;
            tmr  <= SW'(SETUP_CYC - 1);
            st   <= ST_GAP;
          end else tmr <= tmr - SW'(1);
        end
        ST_GAP: begin
          if (tmr != '0) begin
            tmr <= tmr - SW'(1);
          end else if (fr == FR_PAGE) begin
            cur_page <= r_page;
            page_ok  <= 1'b1;
            fr   <= r_wr ? FR_WRITE : FR_READ;
            rs   <= RS_HEAD;
            hc   <= '0;
            ss_n <= 1'b0;
            tmr  <= SW'(SETUP_CYC - 1);
            st   <= ST_SEL;
          end else begin
            done    <= 1'b1;
            timeout <= timed_out;
            rdata   <= r_wr ? '0 : acc;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/paged_spi_reg_master.sv
module paged_spi_reg_master #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int ACK_TRIES = 100,
  parameter int MAX_BYTES = 4,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int DW = 8 * MAX_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [7:0]    page,
  input  logic [7:0]    ofs,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          timeout,
  output logic          bad_len,
  output logic          spi_ss_n,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  // clocks per microsecond, rounded up, never below one
  localparam int CYC_US    = (CLK_HZ <= 1_000_000) ? 1 : (CLK_HZ + 999_999) / 1_000_000;
  localparam int PHASE_CYC = 2 * CYC_US;
  localparam int SETUP_CYC = CYC_US;

  logic       phy_go, phy_fin;
  logic [7:0] phy_tx, phy_rx;

  regspi_seq #(
    .SETUP_CYC(SETUP_CYC),
    .ACK_TRIES(ACK_TRIES),
    .MAX_BYTES(MAX_BYTES)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .page(page), .ofs(ofs),
    .len(len), .wdata(wdata), .phy_go(phy_go), .phy_tx(phy_tx),
    .phy_fin(phy_fin), .phy_rx(phy_rx), .ss_n(spi_ss_n), .rdata(rdata),
    .done(done), .timeout(timeout), .bad_len(bad_len)
  );

  regspi_byte_phy #(.PHASE_CYC(PHASE_CYC)) u_phy (
    .clk(clk), .rst(rst), .go(phy_go), .tx(phy_tx), .fin(phy_fin),
    .rx(phy_rx), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/paged_spi_reg_master_chk.sv
module paged_spi_reg_master_chk (
  input logic clk,
  input logic rst,
  input logic done,
  input logic timeout,
  input logic bad_len,
  input logic spi_ss_n,
  input logic spi_sclk,
  input logic spi_mosi
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    spi_ss_n |-> (!spi_sclk && !spi_mosi));
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  // R3
  high_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |=> spi_sclk);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  flag_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout || bad_len) |-> done);
  // R8
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> spi_ss_n);
  // R9
  badlen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done && bad_len) |-> (spi_ss_n && $past(spi_ss_n)));
endmodule

bind paged_spi_reg_master paged_spi_reg_master_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .timeout(timeout), .bad_len(bad_len),
  .spi_ss_n(spi_ss_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/paged_spi_reg_master_test.sv
module paged_spi_reg_master_test;
  localparam int CLK_HZ = 2_000_000;
  localparam int PH     = 4;   // 2 us at 2 MHz
  localparam int SU     = 2;   // 1 us at 2 MHz
  localparam int TRIES  = 100;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, wr = 1'b0, miso = 1'b0;
  logic [7:0]  page = '0, ofs = '0;
  logic [2:0]  len = '0;
  logic [31:0] wdata = '0, rdata;
  logic        done, timeout, bad_len, ss_n, sclk, mosi;

  paged_spi_reg_master #(.CLK_HZ(CLK_HZ), .ACK_TRIES(TRIES)) uut (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .page(page), .ofs(ofs),
    .len(len), .wdata(wdata), .rdata(rdata), .done(done), .timeout(timeout),
    .bad_len(bad_len), .spi_ss_n(ss_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso)
  );

  initial forever #4 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] fb [0:7][0:127];
  int fl [0:7];
  int nfr = 0, nack = 0, done_cnt = 0;
  logic [7:0] rdat [0:3];
  logic [7:0] ex [$];
  logic [31:0] res_rd;
  logic res_to, res_bl;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_byte(int fi, int i);
    int j;
    if (i < 2 || fi > 7) return 8'h00;
    if (fb[fi][0] != 8'h10) return 8'h00;
    j = i - 2;
    if (j < nack) return 8'hFE;
    if (j == nack) return 8'h01;
    if (j - nack - 1 < 4) return rdat[j - nack - 1];
    return 8'h00;
  endfunction

  // switch model, line monitor and per-clock timing comparison
  initial begin
    logic prev_ss, prev_sclk;
    logic [7:0] curb, rb;
    int run, since, nbits;
    prev_ss = 1'b1; prev_sclk = 1'b0; run = 0; since = 0; nbits = 0; curb = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        run++;
        if (done) done_cnt++;
        if (ss_n && (sclk || mosi)) chk(0, "R1", "idle lines", {sclk, mosi}, 0);
        if (prev_ss && !ss_n) begin
          nbits = 0; since = 0; run = 0; miso = 1'b0;
        end
        if (!ss_n) since++;
        if (!ss_n && !prev_sclk && sclk) begin
          if (nbits == 0) chk(since >= SU + 1, "R3", "select setup", since, SU + 1);
          else chk(run >= PH, "R3", "low phase", run, PH);
          curb = {curb[6:0], mosi};
          nbits++;
          if (nbits % 8 == 0 && nbits / 8 <= 128 && nfr < 8) fb[nfr][nbits/8 - 1] = curb;
          run = 0;
        end
        if (!ss_n && prev_sclk && !sclk) begin
          chk(run >= PH, "R3", "high phase", run, PH);
          run = 0;
          rb = resp_byte(nfr, nbits / 8);
          miso = rb[7 - (nbits % 8)];
        end
        if (!prev_ss && ss_n) begin
          chk(run >= SU, "R3", "select hold", run, SU);
          chk(nbits % 8 == 0, "R2", "whole bytes", nbits, 0);
          if (nfr < 8) fl[nfr] = nbits / 8;
          nfr++;
          miso = 1'b0;
        end
      end
      prev_ss = ss_n; prev_sclk = sclk;
    end
  end

  task automatic access(input logic w, input logic [7:0] pg, input logic [7:0] of,
                        input logic [2:0] ln, input logic [31:0] wd);
    nfr = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b1; wr = w; page = pg; ofs = of; len = ln; wdata = wd;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    res_rd = rdata; res_to = timeout; res_bl = bad_len;
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
  endtask

  task automatic chk_frame(input int fi, input string req);
    chk(fl[fi] == ex.size(), req, "frame length", fl[fi], ex.size());
    foreach (ex[k]) chk(fb[fi][k] == ex[k], req, "frame byte", fb[fi][k], ex[k]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(ss_n && !sclk && !mosi && !done && !timeout && !bad_len, "R1", "reset state",
        {ss_n, sclk, mosi, done, timeout, bad_len}, 6'b100000);
    rst = 1'b0;

    // first access: page frame after reset, 4-byte write
    access(1'b1, 8'h34, 8'h08, 3'd4, 32'hA1B2C3D4);
    chk(nfr == 2, "R4", "frame count", nfr, 2);
    ex = '{8'h61, 8'hFF, 8'h34}; chk_frame(0, "R4");
    ex = '{8'h61, 8'h08, 8'hD4, 8'hC3, 8'hB2, 8'hA1}; chk_frame(1, "R6");
    chk(!res_to && !res_bl, "R6", "flags", {res_to, res_bl}, 0);

    // same page: no page frame
    access(1'b1, 8'h34, 8'h10, 3'd2, 32'h0000_1234);
    chk(nfr == 1, "R5", "frame count", nfr, 1);
    ex = '{8'h61, 8'h10, 8'h34, 8'h12}; chk_frame(0, "R6");

    // read after three refusals
    nack = 3; rdat[0] = 8'h97; rdat[1] = 8'h53;
    access(1'b0, 8'h02, 8'h30, 3'd2, 32'h0);
    chk(nfr == 2, "R4", "frame count", nfr, 2);
    ex = '{8'h61, 8'hFF, 8'h02}; chk_frame(0, "R4");
    chk(fb[1][0] == 8'h10 && fb[1][1] == 8'h30, "R7", "read header", {fb[1][0], fb[1][1]}, 16'h1030);
    chk(fl[1] == 8, "R7", "read frame length", fl[1], 8);
    chk(res_rd == 32'h0000_5397, "R7", "rdata 2 bytes", res_rd, 32'h5397);
    chk(!res_to, "R7", "no timeout", res_to, 0);

    // immediate acknowledge, one byte
    nack = 0; rdat[0] = 8'hAB;
    access(1'b0, 8'h02, 8'h05, 3'd1, 32'h0);
    chk(nfr == 1, "R5", "frame count", nfr, 1);
    chk(fl[0] == 4, "R7", "read frame length", fl[0], 4);
    chk(res_rd == 32'h0000_00AB, "R7", "rdata 1 byte", res_rd, 32'hAB);

    // five refusals, four bytes
    nack = 5; rdat[0] = 8'h11; rdat[1] = 8'h22; rdat[2] = 8'h33; rdat[3] = 8'h44;
    access(1'b0, 8'h02, 8'h0C, 3'd4, 32'h0);
    chk(fl[0] == 12, "R7", "read frame length", fl[0], 12);
    chk(res_rd == 32'h4433_2211, "R7", "rdata 4 bytes", res_rd, 32'h44332211);

    // acknowledge never arrives
    nack = 1000;
    access(1'b0, 8'h02, 8'h30, 3'd2, 32'h0);
    chk(res_to == 1'b1, "R8", "timeout flag", res_to, 1);
    chk(nfr == 1 && fl[0] == 2 + TRIES, "R8", "polled bytes", fl[0], 2 + TRIES);

    // cache survives the timeout
    access(1'b1, 8'h02, 8'h0E, 3'd1, 32'h0000_005A);
    chk(nfr == 1, "R5", "frame count after timeout", nfr, 1);
    ex = '{8'h61, 8'h0E, 8'h5A}; chk_frame(0, "R6");

    // rejected lengths
    for (int l = 0; l < 8; l += 3) begin
      nfr = 0;
      @(negedge clk);
      start = 1'b1; wr = 1'b1; page = 8'h07; len = 3'(l);
      @(negedge clk);
      start = 1'b0;
      chk(done && bad_len && ss_n, "R9", "bad length reply", {done, bad_len, ss_n}, 3'b111);
      repeat (20) @(negedge clk);
      chk(nfr == 0 && ss_n, "R9", "no frame", nfr, 0);
    end
    // page 07 never cached: page 02 still current
    access(1'b1, 8'h02, 8'h01, 3'd1, 32'h0000_0033);
    chk(nfr == 1, "R9", "cache unchanged", nfr, 1);

    // second start while busy is ignored
    nfr = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b1; wr = 1'b1; page = 8'h02; ofs = 8'h20; len = 3'd1; wdata = 32'h77;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    start = 1'b1; page = 8'h09; ofs = 8'h40; len = 3'd4; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (600) @(negedge clk);
    chk(nfr == 1 && done_cnt == 1, "R10", "busy start ignored", {nfr[7:0], done_cnt[7:0]}, 16'h0101);
    ex = '{8'h61, 8'h20, 8'h77}; chk_frame(0, "R10");

    // move to another page
    access(1'b1, 8'h05, 8'h00, 3'd1, 32'h0000_00C3);
    chk(nfr == 2, "R4", "frame count", nfr, 2);
    ex = '{8'h61, 8'hFF, 8'h05}; chk_frame(0, "R4");
    ex = '{8'h61, 8'h00, 8'hC3}; chk_frame(1, "R6");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule